// File: doc/BRIEF.md
# Protection Region Address Decoder

This block turns one protection entry's programmed state into a plain inclusive byte range. It takes the entry's two-bit match mode, the entry's own address register and the address register of the entry below it. It returns a start byte address, an end byte address and a flag that says whether the range may take part in matching. Once every entry has been decoded this way, checking an access against an entry takes two magnitude comparisons.

Each address register holds bits 33:2 of a 34-bit physical byte address. The decoder is purely combinational and is meant to be instantiated once per entry. The lowest entry ties its previous-address input to zero. Range lookup against access addresses happens elsewhere.

Top module: `prad_decoder`

## Requirements
- R1: The mode input is decoded as 0 = disabled, 1 = top-of-range (TOR), 2 = single aligned word of 4 bytes (NA4), 3 = naturally aligned power-of-two region (NAPOT).
- R2: In disabled mode the start is 0, the end is 0x3_FFFF_FFFF and the valid flag is 0, so the entry never matches.
- R3: In TOR mode the start equals the previous register times 4 and the end equals this register times 4 minus 1. The valid flag is 1 exactly when this register is greater than the previous one.
- R4: In TOR mode with this register equal to 0, the end is reported as 0 instead of wrapping, and the valid flag is 0.
- R5: When the previous input is 0, which is the tie-off for the lowest entry, a TOR range starts at byte 0.
- R6: In NA4 mode the start is the register times 4, the end is the start plus 3 and the valid flag is 1.
- R7: In NAPOT mode, t trailing one bits in the register select a region of 2^(t+3) bytes. The start is the register with those t bits cleared, times 4. The end is the start plus the size minus 1, and the valid flag is 1.
- R8: In NAPOT mode a register of all ones covers the whole space, from 0 to 0x3_FFFF_FFFF. A register of 0x7FFF_FFFF does the same.
- R9: The outputs depend only on the present inputs. A change of any input is visible in the same cycle and leaves no state behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 2 | Match mode of this entry |
| this_addr_i | input | 32 | This entry's address register (byte address bits 33:2) |
| prev_addr_i | input | 32 | Address register of the entry below; 0 for the lowest entry |
| start_o | output | 34 | Inclusive start byte address |
| end_o | output | 34 | Inclusive end byte address |
| valid_o | output | 1 | Range may be used for matching |

## Verification
Two things often change in the same cycle: the mode and the address registers. One decode path may then read a register value meant for another. For example, an entry switches from NAPOT to TOR while its own register and its neighbour's register both move. The bench changes all three inputs on every cycle, using directed corners and a long pseudo-random run. A behavioural model computes the expected range with plain integer arithmetic, a loop for trailing ones and explicit clamping. Each cycle the bench compares all three outputs against that model.

// File: rtl/prad_pkg.sv
package prad_pkg;
   typedef enum logic [1:0] {
      PRAD_OFF   = 2'd0,
      PRAD_TOR   = 2'd1,
      PRAD_NA4   = 2'd2,
      PRAD_NAPOT = 2'd3
   } prad_mode_e;
endpackage

// File: rtl/prad_ones_count.sv
// Priority encoder: number of consecutive ones starting at bit 0.
module prad_ones_count #(
   parameter int AREG_W = 32,
   localparam int CW = $clog2(AREG_W + 1),
   localparam int IW = $clog2(AREG_W)
) (
   input  logic [AREG_W-1:0] vec_i,
   output logic [CW-1:0]     cnt_o
);
   generate
      if (AREG_W < 2) begin : g_bad_width
         $error("prad_ones_count: AREG_W must be at least 2");
      end
   endgenerate

   always_comb begin
      cnt_o = CW'(AREG_W);
      for (int i = AREG_W - 1; i >= 0; i--) begin
         if (!vec_i[i]) cnt_o = CW'(i);
      end
   end

   // R7: the bit just above the counted ones is zero and all below are one
   always_comb begin
      if (int'(cnt_o) < AREG_W) begin
         a_r7_first_zero: assert (!vec_i[cnt_o[IW-1:0]])
            else $error("count does not land on a zero bit");
      end
      if (cnt_o != '0) begin
         a_r7_low_ones: assert (vec_i[cnt_o[IW-1:0] - IW'(1)])
            else $error("bit below count is not one");
      end
   end
endmodule

// File: rtl/prad_napot.sv
// Power-of-two region decode from a trailing-ones count.
module prad_napot #(
   parameter int AREG_W = 32,
   localparam int CW   = $clog2(AREG_W + 1),
   localparam int PA_W = AREG_W + 2
) (
   input  logic [AREG_W-1:0] areg_i,
   input  logic [CW-1:0]     cnt_i,
   output logic [PA_W-1:0]   base_o,
   output logic [PA_W-1:0]   last_o
);
   logic [AREG_W-1:0] span;   // register bits covered by the region

   generate
      for (genvar i = 0; i < AREG_W; i++) begin : g_span
         assign span[i] = (CW'(i) <= cnt_i);
      end
   endgenerate

   assign base_o = {areg_i & ~span, 2'b00};
   assign last_o = {areg_i | span, 2'b11};

   // R7: region is ordered and its base is aligned to its size
   always_comb begin
      a_r7_ordered: assert (base_o <= last_o)
         else $error("napot base above end");
      a_r7_aligned: assert (((last_o - base_o) & base_o) == '0)
         else $error("napot base not aligned to region size");
   end
endmodule

// File: rtl/prad_linear.sv
// TOR and NA4 range arithmetic with clamping at both ends of the space.
module prad_linear #(
   parameter int AREG_W = 32,
   localparam int PA_W = AREG_W + 2
) (
   input  logic [AREG_W-1:0] this_i,
   input  logic [AREG_W-1:0] prev_i,
   output logic [PA_W-1:0]   tor_start_o,
   output logic [PA_W-1:0]   tor_end_o,
   output logic              tor_ok_o,
   output logic [PA_W-1:0]   word_start_o,
   output logic [PA_W-1:0]   word_end_o
);
   logic [PA_W:0] word_sum;

   function automatic logic [PA_W-1:0] clamp_top(input logic [PA_W:0] x);
      return x[PA_W] ? {PA_W{1'b1}} : x[PA_W-1:0];
   endfunction

   assign tor_start_o  = {prev_i, 2'b00};
   assign tor_end_o    = (this_i == '0) ? '0 : ({this_i, 2'b00} - PA_W'(1));
   assign tor_ok_o     = (this_i > prev_i);
   assign word_start_o = {this_i, 2'b00};
   assign word_sum     = {1'b0, this_i, 2'b00} + (PA_W + 1)'(3);
   assign word_end_o   = clamp_top(word_sum);

   // R4: an empty TOR range is flagged unusable and never wraps
   always_comb begin
      if (this_i == '0) begin
         a_r4_no_wrap: assert (tor_end_o == '0 && !tor_ok_o)
            else $error("tor end wrapped");
      end
      if (tor_ok_o) begin
         a_r3_tor_order: assert (tor_start_o <= tor_end_o)
            else $error("usable tor range inverted");
      end
   end
endmodule

// File: rtl/prad_decoder.sv
module prad_decoder
   import prad_pkg::*;
#(
   parameter int AREG_W = 32,
   localparam int PA_W = AREG_W + 2,
   localparam int CW   = $clog2(AREG_W + 1)
) (
   input  logic [1:0]        mode_i,
   input  logic [AREG_W-1:0] this_addr_i,
   input  logic [AREG_W-1:0] prev_addr_i,
   output logic [PA_W-1:0]   start_o,
   output logic [PA_W-1:0]   end_o,
   output logic              valid_o
);
   prad_mode_e        mode;
   logic [CW-1:0]     ones;
   logic [PA_W-1:0]   np_base, np_last;
   logic [PA_W-1:0]   tor_s, tor_e, na_s, na_e;
   logic              tor_ok;

   assign mode = prad_mode_e'(mode_i);

   prad_ones_count #(.AREG_W(AREG_W)) u_count (
      .vec_i (this_addr_i),
      .cnt_o (ones)
   );

   prad_napot #(.AREG_W(AREG_W)) u_napot (
      .areg_i (this_addr_i),
      .cnt_i  (ones),
      .base_o (np_base),
      .last_o (np_last)
   );

   prad_linear #(.AREG_W(AREG_W)) u_linear (
      .this_i       (this_addr_i),
      .prev_i       (prev_addr_i),
      .tor_start_o  (tor_s),
      .tor_end_o    (tor_e),
      .tor_ok_o     (tor_ok),
      .word_start_o (na_s),
      .word_end_o   (na_e)
   );

   // R1: mode selects one of the decoded ranges
   always_comb begin
      unique case (mode)
         PRAD_TOR:   begin start_o = tor_s;   end_o = tor_e;   valid_o = tor_ok; end
         PRAD_NA4:   begin start_o = na_s;    end_o = na_e;    valid_o = 1'b1;   end
         PRAD_NAPOT: begin start_o = np_base; end_o = np_last; valid_o = 1'b1;   end
         default:    begin start_o = '0;      end_o = '1;      valid_o = 1'b0;   end
      endcase
   end

   always_comb begin
      if (mode_i == 2'd0) begin
         a_r2_off_unusable: assert (!valid_o)
            else $error("disabled entry flagged usable");
      end
      if (mode_i == 2'd2) begin
         a_r6_word_span: assert (end_o - start_o == PA_W'(3))
            else $error("word region not four bytes");
      end
      if (mode_i == 2'd3 && this_addr_i == '1) begin
         a_r8_full_space: assert (start_o == '0 && end_o == '1)
            else $error("all-ones region not full space");
      end
   end
endmodule

// File: tb/prad_decoder_test.sv
module prad_decoder_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  mode;
   logic [31:0] this_a, prev_a;
   logic [33:0] st, en;
   logic        vl;
   int total = 0;
   int bad = 0;
   logic [31:0] lfsr = 32'h1234_5678;

   always #5 clk = ~clk;

   prad_decoder uut (
      .mode_i (mode), .this_addr_i (this_a), .prev_addr_i (prev_a),
      .start_o (st), .end_o (en), .valid_o (vl)
   );

   function automatic void model(input logic [1:0] m, input logic [31:0] a,
                                 input logic [31:0] p, output logic [33:0] s,
                                 output logic [33:0] e, output logic v);
      longint unsigned top = (64'd1 << 34) - 1;
      longint unsigned b, sz, x;
      int t;
      case (m)
         2'd1: begin
            s = 34'(longint'(p) * 4);
            e = (a == 0) ? 34'd0 : 34'(longint'(a) * 4 - 1);
            v = (a > p);
         end
         2'd2: begin
            s = 34'(longint'(a) * 4);
            x = longint'(a) * 4 + 3;
            e = (x > top) ? 34'(top) : 34'(x);
            v = 1'b1;
         end
         2'd3: begin
            t = 0;
            while (t < 32 && a[t]) t++;
            b = (t == 32) ? 64'd0 : (((longint'(a) >> t) << t) * 4);
            sz = 64'd1 << (t + 3);
            x = b + sz - 1;
            s = 34'(b);
            e = (x > top) ? 34'(top) : 34'(x);
            v = 1'b1;
         end
         default: begin s = 34'd0; e = 34'(top); v = 1'b0; end
      endcase
   endfunction

   task automatic check(input string tag);
      logic [33:0] es, ee;
      logic ev;
      model(mode, this_a, prev_a, es, ee, ev);
      total++;
      if (st !== es || en !== ee || vl !== ev) begin
         bad++;
         $display("FAIL %s mode=%0d a=%h p=%h got s=%h e=%h v=%b exp s=%h e=%h v=%b",
                  tag, mode, this_a, prev_a, st, en, vl, es, ee, ev);
      end
   endtask

   task automatic apply(input logic [1:0] m, input logic [31:0] a,
                        input logic [31:0] p, input string tag);
      @(negedge clk);
      mode = m; this_a = a; prev_a = p;
      #1 check(tag);
   endtask

   initial begin
      #200000;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      mode = 2'd0; this_a = '0; prev_a = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk); #1 check("R2 reset state");
      apply(2'd0, 32'hFFFF_0000, 32'h10, "R2 off with nonzero regs");
      apply(2'd1, 32'h0000_0100, 32'h0000_0040, "R3 tor basic");
      apply(2'd1, 32'h0000_0100, 32'h0, "R5 tor lowest entry");
      apply(2'd1, 32'h0, 32'h0, "R4 tor zero register");
      apply(2'd1, 32'h40, 32'h40, "R4 tor equal regs empty");
      apply(2'd1, 32'h20, 32'h40, "R3 tor inverted regs");
      apply(2'd1, 32'hFFFF_FFFF, 32'h0, "R3 tor top");
      apply(2'd2, 32'h0000_1000, 32'h5, "R6 word");
      apply(2'd2, 32'hFFFF_FFFF, 32'h0, "R6 word at top");
      apply(2'd3, 32'h0000_1000, 32'h0, "R7 napot t=0");
      apply(2'd3, 32'h0000_10FF, 32'h0, "R7 napot t=8");
      apply(2'd3, 32'h8000_0001, 32'h0, "R7 napot t=1 high base");
      apply(2'd3, 32'hFFFF_FFFF, 32'h0, "R8 napot all ones");
      apply(2'd3, 32'h7FFF_FFFF, 32'h0, "R8 napot one zero at top");
      // R1 and R9: mode and both registers change together every cycle
      apply(2'd3, 32'h0000_0007, 32'h0, "R9 napot before switch");
      apply(2'd1, 32'h0000_0200, 32'h0000_0007, "R9 switch to tor same cycle");
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] a, p;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         a = lfsr;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         p = lfsr;
         if (i % 4 == 3) a = a | ((32'd1 << (i % 32)) - 1);
         apply(lfsr[1:0], a, p, "R1 random");
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule